// File: doc/BRIEF.md
# Flash self-programming command controller

This block sits between a CPU core and a paged program flash. Software arms a command by writing a small control register, then issues a store strobe. The block then checks the target address and sends one command to the flash array. It can load one word into the page buffer, erase a page, write the page buffer into a page, or clear the buffer. The program memory has two regions. The lower, "background" region can be rewritten while code keeps running from the upper, "foreground" region. Rewriting the foreground region halts the CPU until the flash reports completion.

A command runs only if the store strobe arrives within a short window after the arming write. Otherwise the command is dropped. The enable bit stays high from arming until the command ends or is dropped. The interrupt request is held high while interrupts are enabled and the enable bit is clear. After an erase or write, the background region stays flagged as busy until software issues the read-enable command. A boot write-protect input blocks erase and write commands whose page lies at or above a boot base address.

The flash command leaves through a valid/ready channel. Once valid is high, it holds its op code, address and data unchanged until the cycle in which ready is high. The channel has no other back-pressure. Erase and write also wait for a one-cycle completion pulse from the array.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: When the block is idle, a control write with bit 0 set arms a command if bits 6:1 select one. The value 000000 selects buffer load, 000001 page erase, 000010 page write and 001000 background read-enable. prog_en reads 1 from the cycle after an arming write. Any other value leaves prog_en at 0. Every accepted write stores bit 7 as the interrupt enable.
- R2: The strobe is accepted on any of the WINDOW (4) clock edges that follow the arming write. If no strobe comes, prog_en is high for exactly WINDOW cycles, then falls, and no flash command is sent.
- R3: A buffer load sends op code 0 with fl_cmd_addr equal to ptr and fl_cmd_data equal to wdata. prog_en clears in the cycle after the handshake.
- R4: A page erase sends op code 1. fl_cmd_addr is ptr with its low log2(PAGE_WORDS) bits forced to zero, and fl_cmd_data is 0. The erase ends on the edge where fl_done is sampled high.
- R5: A page write sends op code 2, with the same address and data rules as erase. If the word bits of ptr are not zero, the write is rejected: no flash command is sent, and prog_en is 0 from the cycle after the strobe.
- R6: While fl_cmd_valid is high and fl_cmd_ready is low, the op code, address and data on the next cycle are unchanged and valid stays high.
- R7: For an erase or write whose page base is at or above fg_base, cpu_stall is high from the cycle after the strobe until fl_done is sampled. For a page below fg_base, cpu_stall stays low.
- R8: bg_busy rises when an erase or write is accepted and stays high after the operation ends. It falls only when a read-enable command is accepted. That command also sends op code 3 to clear the page buffer.
- R9: irq equals the stored interrupt enable ANDed with the inverse of prog_en.
- R10: While boot_wp is high, an erase or write whose page base is at or above boot_base is rejected. No flash command is sent, prog_en falls and bg_busy is unchanged. Loads are not affected.
- R11: A control write while a command is armed or running is ignored, including its interrupt-enable bit. A strobe while not armed is ignored.
- R12: After reset, prog_en, bg_busy, cpu_stall, irq and fl_cmd_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| prog_strobe | input | 1 | Store strobe from the CPU |
| ptr | input | ADDR_W | Word address pointer |
| wdata | input | DATA_W | Data word for buffer load |
| fg_base | input | ADDR_W | First word address of the foreground region |
| boot_base | input | ADDR_W | First word address of the boot region |
| boot_wp | input | 1 | Boot region write-protect |
| fl_cmd_valid | output | 1 | Flash command valid |
| fl_cmd_ready | input | 1 | Flash command ready |
| fl_cmd_op | output | 2 | Op code: 0 load, 1 erase, 2 write, 3 clear buffer |
| fl_cmd_addr | output | ADDR_W | Flash command word address |
| fl_cmd_data | output | DATA_W | Flash command data |
| fl_done | input | 1 | One-cycle completion pulse for erase and write |
| cpu_stall | output | 1 | Halts the CPU during a foreground rewrite |
| bg_busy | output | 1 | Background region blocked for reading |
| prog_en | output | 1 | Enable bit: armed or running |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, that:
- the flash channel holds its payload under back-pressure;
- no flash command appears without a strobe on the edge before;
- the armed time without a strobe never exceeds the window;
- bg_busy only falls on a strobe;
- a stall always implies busy and enable;
- irq never coincides with prog_en;
- erase and write addresses are page-aligned with zero data;
- no erase or write reaches a protected boot page.

Only the bench scenarios can show:
- the exact decoding of all 256 control values;
- the accept-or-drop edge of the strobe window;
- the exact stall length per region under varied ready and done latency;
- the rejection of unaligned writes;
- that writes landing while a command is armed or running leave the command and interrupt enable untouched.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  localparam int unsigned CTL_W  = 8;
  localparam int unsigned GO_BIT = 0;
  localparam int unsigned IE_BIT = 7;

  localparam logic [5:0] SEL_LOAD  = 6'b000000;
  localparam logic [5:0] SEL_ERASE = 6'b000001;
  localparam logic [5:0] SEL_WRITE = 6'b000010;
  localparam logic [5:0] SEL_RDEN  = 6'b001000;

  typedef enum logic [1:0] {
    FOP_LOAD   = 2'd0,
    FOP_ERASE  = 2'd1,
    FOP_WRITE  = 2'd2,
    FOP_CLRBUF = 2'd3
  } flash_op_e;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_LOAD,
    CK_ERASE,
    CK_WRITE,
    CK_RDEN
  } cmd_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;

  function automatic flash_op_e kind_to_op(input cmd_kind_e k);
    case (k)
      CK_ERASE: return FOP_ERASE;
      CK_WRITE: return FOP_WRITE;
      CK_RDEN:  return FOP_CLRBUF;
      default:  return FOP_LOAD;
    endcase
  endfunction

  function automatic logic is_array_op(input cmd_kind_e k);
    return (k == CK_ERASE) || (k == CK_WRITE);
  endfunction

endpackage

// File: rtl/fsp_cmd_decode.sv
module fsp_cmd_decode
  import fsp_pkg::*;
(
  input  logic [CTL_W-1:0] ctl_val,
  output cmd_kind_e        kind,
  output logic             ie_bit
);

  // Bit 7 is a don't-care for command selection; it carries interrupt enable.
  always_comb begin
    kind = CK_NONE;
    if (ctl_val[GO_BIT]) begin
      case (ctl_val[6:1])
        SEL_LOAD:  kind = CK_LOAD;
        SEL_ERASE: kind = CK_ERASE;
        SEL_WRITE: kind = CK_WRITE;
        SEL_RDEN:  kind = CK_RDEN;
        default:   kind = CK_NONE;
      endcase
    end
  end

  assign ie_bit = ctl_val[IE_BIT];

endmodule

// File: rtl/fsp_addr_split.sv
module fsp_addr_split
  import fsp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned PAGE_WORDS = 32
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] fg_base,
  input  logic [ADDR_W-1:0] boot_base,
  input  logic              boot_wp,
  input  cmd_kind_e         kind,
  output logic [ADDR_W-1:0] page_base,
  output logic [ADDR_W-1:0] word_addr,
  output logic              tgt_fg,
  output logic              word_nonzero,
  output logic              protect_hit
);

  localparam int unsigned WORD_W = $clog2(PAGE_WORDS);
  localparam int unsigned PAGE_W = ADDR_W - WORD_W;

  logic [PAGE_W-1:0] page_num;
  logic [WORD_W-1:0] word_idx;

  assign page_num     = ptr[ADDR_W-1:WORD_W];
  assign word_idx     = ptr[WORD_W-1:0];
  assign page_base    = {page_num, {WORD_W{1'b0}}};
  assign word_addr    = {page_num, word_idx};
  assign word_nonzero = |word_idx;
  assign tgt_fg       = (page_base >= fg_base);
  assign protect_hit  = boot_wp && (page_base >= boot_base) && is_array_op(kind);

endmodule

// File: rtl/fsp_window_timer.sv
module fsp_window_timer #(
  parameter int unsigned WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expired
);

  localparam int unsigned CW = $clog2(WINDOW + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CW'(WINDOW - 1);
    end else if (run && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/fsp_seq.sv
module fsp_seq
  import fsp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  cmd_kind_e         ctl_kind,
  input  logic              ctl_ie,
  input  logic              prog_strobe,
  input  logic [ADDR_W-1:0] page_base,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              tgt_fg,
  input  logic              word_nonzero,
  input  logic              protect_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              win_expired,
  input  logic              fl_cmd_ready,
  input  logic              fl_done,
  output cmd_kind_e         kind_q,
  output logic              win_start,
  output logic              win_run,
  output logic              fl_cmd_valid,
  output logic [1:0]        fl_cmd_op,
  output logic [ADDR_W-1:0] fl_cmd_addr,
  output logic [DATA_W-1:0] fl_cmd_data,
  output logic              cpu_stall,
  output logic              bg_busy,
  output logic              prog_en,
  output logic              irq
);

  seq_state_e        state;
  flash_op_e         op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              fg_q;
  logic              ie_q;
  logic              busy_q;

  logic accept_ctl;
  logic arm;
  logic strobe_hit;
  logic reject;
  logic array_cmd;

  assign accept_ctl = ctl_we && (state == ST_IDLE);
  assign arm        = accept_ctl && (ctl_kind != CK_NONE);
  assign strobe_hit = (state == ST_ARMED) && prog_strobe;
  assign array_cmd  = is_array_op(kind_q);
  assign reject     = protect_hit || ((kind_q == CK_WRITE) && word_nonzero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind_q <= CK_NONE;
      op_q   <= FOP_LOAD;
      addr_q <= '0;
      data_q <= '0;
      fg_q   <= 1'b0;
      ie_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept_ctl) begin
            ie_q <= ctl_ie;
          end
          if (arm) begin
            kind_q <= ctl_kind;
            state  <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (strobe_hit) begin
            if (reject) begin
              state <= ST_IDLE;
            end else begin
              state  <= ST_ISSUE;
              op_q   <= kind_to_op(kind_q);
              addr_q <= (kind_q == CK_LOAD) ? word_addr : page_base;
              data_q <= (kind_q == CK_LOAD) ? wdata : '0;
              fg_q   <= tgt_fg && array_cmd;
              if (array_cmd) begin
                busy_q <= 1'b1;
              end else if (kind_q == CK_RDEN) begin
                busy_q <= 1'b0;
              end
            end
          end else if (win_expired) begin
            state <= ST_IDLE;
          end
        end
        ST_ISSUE: begin
          if (fl_cmd_ready) begin
            state <= ((op_q == FOP_ERASE) || (op_q == FOP_WRITE)) ? ST_WAIT : ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (fl_done) begin
            state <= ST_IDLE;
            fg_q  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign win_start    = arm;
  assign win_run      = (state == ST_ARMED);
  assign fl_cmd_valid = (state == ST_ISSUE);
  assign fl_cmd_op    = op_q;
  assign fl_cmd_addr  = addr_q;
  assign fl_cmd_data  = data_q;
  assign cpu_stall    = fg_q && ((state == ST_ISSUE) || (state == ST_WAIT));
  assign bg_busy      = busy_q;
  assign prog_en      = (state != ST_IDLE);
  assign irq          = ie_q && (state == ST_IDLE);

endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import fsp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PAGE_WORDS = 32,
  parameter int unsigned WINDOW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  input  logic              prog_strobe,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] fg_base,
  input  logic [ADDR_W-1:0] boot_base,
  input  logic              boot_wp,
  output logic              fl_cmd_valid,
  input  logic              fl_cmd_ready,
  output logic [1:0]        fl_cmd_op,
  output logic [ADDR_W-1:0] fl_cmd_addr,
  output logic [DATA_W-1:0] fl_cmd_data,
  input  logic              fl_done,
  output logic              cpu_stall,
  output logic              bg_busy,
  output logic              prog_en,
  output logic              irq
);

  cmd_kind_e         ctl_kind;
  cmd_kind_e         kind_q;
  logic              ctl_ie;
  logic [ADDR_W-1:0] page_base;
  logic [ADDR_W-1:0] word_addr;
  logic              tgt_fg;
  logic              word_nonzero;
  logic              protect_hit;
  logic              win_start;
  logic              win_run;
  logic              win_expired;

  fsp_cmd_decode u_dec (
    .ctl_val (ctl_wdata),
    .kind    (ctl_kind),
    .ie_bit  (ctl_ie)
  );

  fsp_addr_split #(
    .ADDR_W     (ADDR_W),
    .PAGE_WORDS (PAGE_WORDS)
  ) u_addr (
    .ptr          (ptr),
    .fg_base      (fg_base),
    .boot_base    (boot_base),
    .boot_wp      (boot_wp),
    .kind         (kind_q),
    .page_base    (page_base),
    .word_addr    (word_addr),
    .tgt_fg       (tgt_fg),
    .word_nonzero (word_nonzero),
    .protect_hit  (protect_hit)
  );

  fsp_window_timer #(
    .WINDOW (WINDOW)
  ) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (win_start),
    .run     (win_run),
    .expired (win_expired)
  );

  fsp_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_we       (ctl_we),
    .ctl_kind     (ctl_kind),
    .ctl_ie       (ctl_ie),
    .prog_strobe  (prog_strobe),
    .page_base    (page_base),
    .word_addr    (word_addr),
    .tgt_fg       (tgt_fg),
    .word_nonzero (word_nonzero),
    .protect_hit  (protect_hit),
    .wdata        (wdata),
    .win_expired  (win_expired),
    .fl_cmd_ready (fl_cmd_ready),
    .fl_done      (fl_done),
    .kind_q       (kind_q),
    .win_start    (win_start),
    .win_run      (win_run),
    .fl_cmd_valid (fl_cmd_valid),
    .fl_cmd_op    (fl_cmd_op),
    .fl_cmd_addr  (fl_cmd_addr),
    .fl_cmd_data  (fl_cmd_data),
    .cpu_stall    (cpu_stall),
    .bg_busy      (bg_busy),
    .prog_en      (prog_en),
    .irq          (irq)
  );

endmodule

// File: rtl/fsp_chk.sv
module fsp_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PAGE_WORDS = 32,
  parameter int unsigned WINDOW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_strobe,
  input logic              prog_en,
  input logic              bg_busy,
  input logic              cpu_stall,
  input logic              irq,
  input logic              boot_wp,
  input logic [ADDR_W-1:0] boot_base,
  input logic              fl_cmd_valid,
  input logic              fl_cmd_ready,
  input logic [1:0]        fl_cmd_op,
  input logic [ADDR_W-1:0] fl_cmd_addr,
  input logic [DATA_W-1:0] fl_cmd_data
);

  localparam int unsigned WORD_W = $clog2(PAGE_WORDS);

  logic array_op;
  assign array_op = (fl_cmd_op == 2'd1) || (fl_cmd_op == 2'd2);

  // Counts enabled cycles that have not yet seen a strobe (R2 window bound).
  int unsigned armed_cycles;
  logic        strobe_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_cycles <= 0;
      strobe_seen  <= 1'b0;
    end else if (!prog_en) begin
      armed_cycles <= 0;
      strobe_seen  <= 1'b0;
    end else if (prog_strobe) begin
      strobe_seen <= 1'b1;
    end else if (!strobe_seen) begin
      armed_cycles <= armed_cycles + 1;
    end
  end

  a_r2_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armed_cycles <= WINDOW);

  a_r3_valid_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid |-> prog_en);

  a_r4_aligned_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid && array_op) |-> ((fl_cmd_addr[WORD_W-1:0] == '0) && (fl_cmd_data == '0)));

  a_r6_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid && !fl_cmd_ready) |=>
      (fl_cmd_valid && $stable(fl_cmd_op) && $stable(fl_cmd_addr) && $stable(fl_cmd_data)));

  a_r7_stall_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |-> (bg_busy && prog_en));

  a_r8_busy_falls_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bg_busy) |-> $past(prog_strobe));

  a_r9_irq_excludes_en: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !prog_en);

  a_r10_boot_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_cmd_valid && array_op && boot_wp) |-> (fl_cmd_addr < boot_base));

  a_r11_cmd_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_cmd_valid) |-> $past(prog_strobe));

endmodule

bind flash_selfprog_ctrl fsp_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .PAGE_WORDS (PAGE_WORDS),
  .WINDOW     (WINDOW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .prog_strobe  (prog_strobe),
  .prog_en      (prog_en),
  .bg_busy      (bg_busy),
  .cpu_stall    (cpu_stall),
  .irq          (irq),
  .boot_wp      (boot_wp),
  .boot_base    (boot_base),
  .fl_cmd_valid (fl_cmd_valid),
  .fl_cmd_ready (fl_cmd_ready),
  .fl_cmd_op    (fl_cmd_op),
  .fl_cmd_addr  (fl_cmd_addr),
  .fl_cmd_data  (fl_cmd_data)
);

// File: tb/flash_selfprog_ctrl_tb.sv
`timescale 1ns/1ps
module flash_selfprog_ctrl_tb;

  localparam int AW  = 8;
  localparam int DW  = 16;
  localparam int PW  = 8;
  localparam int WIN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_we = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic          prog_strobe = 1'b0;
  logic [AW-1:0] ptr = '0;
  logic [DW-1:0] wdata = '0;
  logic [AW-1:0] fg_base = 8'hC0;
  logic [AW-1:0] boot_base = 8'hE0;
  logic          boot_wp = 1'b0;
  logic          fl_cmd_valid;
  logic          fl_cmd_ready = 1'b0;
  logic [1:0]    fl_cmd_op;
  logic [AW-1:0] fl_cmd_addr;
  logic [DW-1:0] fl_cmd_data;
  logic          fl_done = 1'b0;
  logic          cpu_stall;
  logic          bg_busy;
  logic          prog_en;
  logic          irq;

  flash_selfprog_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_WORDS(PW), .WINDOW(WIN)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .prog_strobe(prog_strobe), .ptr(ptr), .wdata(wdata), .fg_base(fg_base),
    .boot_base(boot_base), .boot_wp(boot_wp), .fl_cmd_valid(fl_cmd_valid),
    .fl_cmd_ready(fl_cmd_ready), .fl_cmd_op(fl_cmd_op), .fl_cmd_addr(fl_cmd_addr),
    .fl_cmd_data(fl_cmd_data), .fl_done(fl_done), .cpu_stall(cpu_stall),
    .bg_busy(bg_busy), .prog_en(prog_en), .irq(irq)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  // Flash array model: ready after rdy_delay cycles of valid, done pulse done_lat cycles after handshake.
  int         rdy_delay = 0;
  int         done_lat  = 1;
  int         vcnt = 0;
  int         done_wait = 0;
  bit         hs_pend = 0;
  logic [1:0] pend_op = '0;

  always @(negedge clk) begin
    if (hs_pend && (pend_op == 2'd1 || pend_op == 2'd2)) done_wait = done_lat;
    if (done_wait > 0) begin
      done_wait = done_wait - 1;
      fl_done = (done_wait == 0);
    end else begin
      fl_done = 1'b0;
    end
    if (fl_cmd_valid) begin
      vcnt = vcnt + 1;
      fl_cmd_ready = (vcnt > rdy_delay);
    end else begin
      vcnt = 0;
      fl_cmd_ready = 1'b0;
    end
    hs_pend = fl_cmd_valid && fl_cmd_ready;
    pend_op = fl_cmd_op;
  end

  // Handshake monitor.
  int            hs_n = 0;
  logic [1:0]    h_op = '0;
  logic [AW-1:0] h_addr = '0;
  logic [DW-1:0] h_data = '0;

  always @(posedge clk) begin
    if (rst_n && fl_cmd_valid && fl_cmd_ready) begin
      hs_n   = hs_n + 1;
      h_op   = fl_cmd_op;
      h_addr = fl_cmd_addr;
      h_data = fl_cmd_data;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_we = 1'b1;
    ctl_wdata = v;
    cyc();
    ctl_we = 1'b0;
  endtask

  task automatic strobe();
    prog_strobe = 1'b1;
    cyc();
    prog_strobe = 1'b0;
  endtask

  task automatic drain(output int st);
    int n = 0;
    st = 0;
    while (prog_en && n < 200) begin
      if (cpu_stall) st++;
      cyc();
      n++;
    end
    cyc();
  endtask

  function automatic bit arms(input logic [7:0] v);
    return v[0] && (v[6:1] == 6'd0 || v[6:1] == 6'd1 || v[6:1] == 6'd2 || v[6:1] == 6'd8);
  endfunction

  task automatic ctl_sweep();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      int hi;
      int n0;
      b = v[7:0];
      n0 = hs_n;
      hi = 0;
      wr_ctl(b);
      chk("R1 prog_en after write", prog_en, arms(b));
      chk("R9 irq while armed", irq, b[7] && !arms(b));
      for (int i = 0; i < 6; i++) begin
        if (prog_en) hi++;
        cyc();
      end
      chk("R2 enabled cycles without strobe", hi, arms(b) ? WIN : 0);
      chk("R2 no flash command", hs_n, n0);
      chk("R9 irq after window", irq, b[7]);
    end
  endtask

  task automatic array_op(input logic [7:0] ctl, input int p, input logic [2:0] w,
                          input bit expect_ok, input string tag);
    int n0;
    int st;
    bit fg;
    logic busy0;
    int exp_st;
    n0 = hs_n;
    busy0 = bg_busy;
    fg = (p >= 24);
    rdy_delay = p % 3;
    done_lat = 1 + p % 4;
    ptr = {p[4:0], w};
    wdata = 16'hBEEF ^ 16'(p);
    wr_ctl(ctl);
    cyc();
    strobe();
    if (!expect_ok) chk({tag, " prog_en cleared on reject"}, prog_en, 0);
    drain(st);
    chk({tag, " command count"}, hs_n, n0 + (expect_ok ? 1 : 0));
    if (expect_ok) begin
      chk({tag, " op"}, h_op, ctl[2] ? 2 : 1);
      chk({tag, " page aligned address"}, h_addr, {p[4:0], 3'b000});
      chk({tag, " data ignored"}, h_data, 0);
      exp_st = fg ? (p % 3) + (p % 4) + 2 : 0;
      chk("R7 stall cycles", st, exp_st);
      chk("R8 busy held after completion", bg_busy, 1);
    end else begin
      chk({tag, " busy unchanged"}, bg_busy, busy0);
    end
  endtask

  task automatic load_op(input int dly, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit expect_ok, input string tag);
    int n0;
    int st;
    n0 = hs_n;
    rdy_delay = dly % 3;
    ptr = a;
    wdata = d;
    wr_ctl(8'h01);
    repeat (dly - 1) cyc();
    strobe();
    drain(st);
    chk({tag, " command count"}, hs_n, n0 + (expect_ok ? 1 : 0));
    if (expect_ok) begin
      chk("R3 load op", h_op, 0);
      chk("R3 load address", h_addr, a);
      chk("R3 load data", h_data, d);
      chk("R7 no stall for load", st, 0);
    end
    chk("R3 prog_en clear after load", prog_en, 0);
  endtask

  task automatic main_seq();
    int n0;
    int st;
    // R12 reset state
    repeat (3) @(negedge clk);
    chk("R12 prog_en", prog_en, 0);
    chk("R12 bg_busy", bg_busy, 0);
    chk("R12 cpu_stall", cpu_stall, 0);
    chk("R12 irq", irq, 0);
    chk("R12 fl_cmd_valid", fl_cmd_valid, 0);
    rst_n = 1'b1;
    cyc();

    ctl_sweep();

    // R2 strobe delay sweep with loads
    for (int d = 1; d <= 6; d++) load_op(d, 8'(8'h40 + d), 16'(16'h1000 * d + d), d <= WIN, "R2 window");

    // R3 load over every word slot of a page
    for (int w = 0; w < PW; w++) load_op(2, {5'd9, w[2:0]}, 16'(16'hA5A5 ^ (w * 257)), 1'b1, "R3 load");

    // R4 erase every page, word bits nonzero and junk data
    for (int p = 0; p < 32; p++) array_op(8'h03, p, p[2:0] ^ 3'b101, 1'b1, "R4 erase");
    // R5 write every page with word bits zero
    for (int p = 0; p < 32; p++) array_op(8'h85, p, 3'b000, 1'b1, "R5 write");
    // R5 unaligned writes rejected
    for (int p = 0; p < 32; p += 5) array_op(8'h05, p, 3'(1 + p % 7), 1'b0, "R5 reject");

    // R8 read-enable clears busy and sends buffer clear
    chk("R8 busy before read-enable", bg_busy, 1);
    n0 = hs_n;
    rdy_delay = 2;
    wr_ctl(8'h11);
    strobe();
    chk("R8 busy cleared", bg_busy, 0);
    drain(st);
    chk("R8 clear-buffer command", hs_n, n0 + 1);
    chk("R8 clear-buffer op", h_op, 3);

    // R10 boot guard
    boot_wp = 1'b1;
    for (int p = 26; p < 32; p++) array_op(8'h03, p, 3'b000, p < 28, "R10 boot erase");
    for (int p = 28; p < 32; p += 3) array_op(8'h05, p, 3'b000, 1'b0, "R10 boot write");
    load_op(1, 8'hF3, 16'h7777, 1'b1, "R10 load in boot region");
    boot_wp = 1'b0;
    array_op(8'h03, 30, 3'b000, 1'b1, "R10 unprotected boot erase");

    // R11 re-write during armed window keeps first command
    n0 = hs_n;
    rdy_delay = 0;
    ptr = 8'h13;
    wdata = 16'h1234;
    wr_ctl(8'h01);
    wr_ctl(8'h05);
    strobe();
    drain(st);
    chk("R11 armed command kept", h_op, 0);
    chk("R11 command count", hs_n, n0 + 1);
    chk("R11 load data", h_data, 16'h1234);

    // R11 write during running erase ignored, interrupt enable stays 0
    ptr = 8'h20;
    rdy_delay = 1;
    done_lat = 6;
    wr_ctl(8'h03);
    strobe();
    wr_ctl(8'h80);
    drain(st);
    chk("R11 irq enable not taken while running", irq, 0);

    // R11 stray strobe while idle
    n0 = hs_n;
    strobe();
    chk("R11 stray strobe prog_en", prog_en, 0);
    repeat (3) cyc();
    chk("R11 stray strobe no command", hs_n, n0);

    // R9 interrupt with a load
    ptr = 8'h05;
    wr_ctl(8'h81);
    chk("R9 irq low while armed", irq, 0);
    strobe();
    drain(st);
    chk("R9 irq high when idle and enabled", irq, 1);
    wr_ctl(8'h00);
    chk("R9 irq low when disabled", irq, 0);
  endtask

  initial begin
    main_seq();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule